// File: doc/BRIEF.md
# Trimmed Seconds Divider

This block divides a 32.768 kHz oscillator clock down to a one-pulse-per-second tick and a once-a-minute strobe. It corrects a crystal's frequency error digitally. No counts are added to or removed from every second. Instead, one second is shortened or stretched at the start of each of a programmed number of minutes, inside a repeating 64-minute frame. The correction acts on the carry out of the first divider stage, which divides by `PRE_DIV`. That stage divides by 256 at the default setting.

A 6-bit trim field sets the correction. Its low five bits give a step count N from 0 to 31, and its top bit gives the direction. With N steps, the first 2N minutes of every frame each carry one corrected second. A faster trim takes one whole prescaler period out of that second. A slower trim adds half a prescaler period to it. At the default settings, each step therefore moves 512 or 256 oscillator cycles per 64-minute frame.

A separate free-running divider produces a square-wave test output that is independent of the trim, so the raw oscillator frequency can be measured. A stop input freezes every counter. A clear pulse, issued by whatever logic writes the time registers, restarts both the second and the frame.

Top module: `ccal_divider`

## Requirements
- R1: With trim step count 0, `sec_pulse` is high for exactly one cycle, and successive pulses are `PRE_DIV*SEC_DIV` oscillator cycles apart, counted from a clear.
- R2: `trim_cfg[4:0]` is the step count N (unsigned) and `trim_cfg[5]` is the direction: 1 means faster (shorter seconds) and 0 means slower (longer seconds).
- R3: The corrected seconds are exactly the first second of each of minutes 0 to 2N-1 of the 64-minute frame, so no minute with index 62 or above is ever corrected.
- R4: A corrected second under a faster trim lasts `PRE_DIV*(SEC_DIV-1)` cycles.
- R5: A corrected second under a slower trim lasts `PRE_DIV*SEC_DIV + PRE_DIV/2` cycles.
- R6: A step count of 0 leaves every second at its nominal length, whatever the direction bit says.
- R7: `min_pulse` is high together with every `SEC_PER_MIN`-th `sec_pulse`. The frame index advances by one per minute and wraps after 64 minutes, so minute 0 of the next frame is corrected again.
- R8: `test_wave` is a square wave with a period of `TST_DIV` oscillator cycles, and the trim value does not change it.
- R9: While `stop` is high, no counter advances, no `sec_pulse` occurs and `test_wave` holds its level. The second being counted is stretched by exactly the number of stopped cycles.
- R10: A `div_clr` pulse restarts the current second, the minute and the 64-minute frame, and also the test divider.
- R11: After reset, `sec_pulse`, `min_pulse` and `test_wave` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stop | input | 1 | Freeze all dividers while high |
| div_clr | input | 1 | Synchronous restart of all dividers and the frame |
| trim_cfg | input | 6 | Bit 5 direction (1 = faster), bits 4:0 step count |
| sec_pulse | output | 1 | One-cycle pulse at the end of each second |
| min_pulse | output | 1 | One-cycle pulse with the last second of each minute |
| test_wave | output | 1 | Untrimmed square-wave test output |

## Verification
Several properties are checked on every cycle by the assertions. The prescaler count stays within its stretched range, and the seconds count stays within its range. Frozen counters hold their value under stop, and a clear or a stop suppresses the next tick. The minute strobe always coincides with a seconds tick, the frame index steps by one per minute, and no minute at index 62 or above is ever marked for correction. Other behaviours can only be shown by the bench scenarios, which measure intervals between pulses. These are the exact lengths of corrected seconds, which seconds in the frame get corrected, the total frame length for each trim setting, the wrap into the next frame, and the period of the test output under extreme trims.

// File: rtl/ccal_pkg.sv
package ccal_pkg;

  typedef struct packed {
    logic       faster;
    logic [4:0] steps;
  } trim_t;

  localparam int FRAME_MIN = 64;

  // A minute index lies in the corrected window when it is below twice the step count.
  function automatic logic in_window(input logic [5:0] fidx, input logic [4:0] steps);
    return ({1'b0, fidx} < {1'b0, steps, 1'b0});
  endfunction

endpackage

// File: rtl/ccal_prescale.sv
module ccal_prescale #(
  parameter int PRE_DIV = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic stretch,
  output logic carry
);
  localparam int LONG = PRE_DIV + PRE_DIV / 2;
  localparam int W    = $clog2(LONG);

  logic [W-1:0] pcnt;
  logic [W-1:0] limit;

  assign limit = stretch ? W'(LONG - 1) : W'(PRE_DIV - 1);
  assign carry = run && !clr && (pcnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pcnt <= '0;
    else if (clr)    pcnt <= '0;
    else if (run)    pcnt <= carry ? '0 : pcnt + W'(1);
  end

  AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= W'(LONG - 1)); // R5
  AST_PRE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(pcnt)); // R9

endmodule

// File: rtl/ccal_secdiv.sv
module ccal_secdiv #(
  parameter int SEC_DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic carry,
  input  logic dbl,
  output logic at_start,
  output logic tick
);
  localparam int W = $clog2(SEC_DIV + 2);

  logic [W-1:0] scnt;
  logic [W-1:0] step;
  logic [W-1:0] nxt;

  assign at_start = (scnt == '0);
  assign step     = (dbl && at_start) ? W'(2) : W'(1);
  assign nxt      = scnt + step;
  assign tick     = carry && (nxt >= W'(SEC_DIV));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      scnt <= '0;
    else if (clr)    scnt <= '0;
    else if (carry)  scnt <= tick ? '0 : nxt;
  end

  AST_SEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    scnt < W'(SEC_DIV)); // R1
  AST_SEC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!carry && !clr) |=> $stable(scnt)); // R9

endmodule

// File: rtl/ccal_sched.sv
module ccal_sched
  import ccal_pkg::*;
#(
  parameter int SEC_PER_MIN = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       sec_tick,
  input  logic [4:0] steps,
  output logic       min_tick,
  output logic       adj
);
  localparam int SW = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
  localparam logic [SW-1:0] LAST = SW'(SEC_PER_MIN - 1);

  logic [SW-1:0] sidx;
  logic [5:0]    fidx;

  assign min_tick = sec_tick && (sidx == LAST);
  assign adj      = (sidx == '0) && in_window(fidx, steps);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sidx <= '0;
      fidx <= '0;
    end else if (clr) begin
      sidx <= '0;
      fidx <= '0;
    end else if (sec_tick) begin
      if (sidx == LAST) begin
        sidx <= '0;
        fidx <= fidx + 6'd1;
      end else begin
        sidx <= sidx + SW'(1);
      end
    end
  end

  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    min_tick |=> (fidx == $past(fidx) + 6'd1)); // R7
  AST_WINDOW_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    adj |-> (fidx < 6'(FRAME_MIN - 2))); // R3

endmodule

// File: rtl/ccal_divider.sv
module ccal_divider
  import ccal_pkg::*;
#(
  parameter int PRE_DIV     = 256,
  parameter int SEC_DIV     = 128,
  parameter int SEC_PER_MIN = 60,
  parameter int TST_DIV     = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop,
  input  logic       div_clr,
  input  logic [5:0] trim_cfg,
  output logic       sec_pulse,
  output logic       min_pulse,
  output logic       test_wave
);
  localparam int TW = $clog2(TST_DIV);

  trim_t         trim;
  logic          run;
  logic          carry;
  logic          at_start;
  logic          tick;
  logic          min_tick;
  logic          adj;
  logic          stretch;
  logic          dbl;
  logic [TW-1:0] tcnt;

  assign trim    = trim_t'(trim_cfg);
  assign run     = !stop;
  assign stretch = adj && at_start && !trim.faster;
  assign dbl     = adj && trim.faster;

  ccal_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(div_clr), .run(run),
    .stretch(stretch), .carry(carry)
  );

  ccal_secdiv #(.SEC_DIV(SEC_DIV)) u_sec (
    .clk(clk), .rst_n(rst_n), .clr(div_clr), .carry(carry),
    .dbl(dbl), .at_start(at_start), .tick(tick)
  );

  ccal_sched #(.SEC_PER_MIN(SEC_PER_MIN)) u_sch (
    .clk(clk), .rst_n(rst_n), .clr(div_clr), .sec_tick(tick),
    .steps(trim.steps), .min_tick(min_tick), .adj(adj)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt      <= '0;
      sec_pulse <= 1'b0;
      min_pulse <= 1'b0;
    end else begin
      sec_pulse <= tick;
      min_pulse <= min_tick;
      if (div_clr)  tcnt <= '0;
      else if (run) tcnt <= tcnt + TW'(1);
    end
  end

  assign test_wave = tcnt[TW-1];

  AST_MIN_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    min_pulse |-> sec_pulse); // R7
  AST_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    div_clr |=> !sec_pulse); // R10
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !div_clr) |=> (!sec_pulse && $stable(test_wave))); // R9

endmodule

// File: tb/sim_ccal_divider.sv
`timescale 1ns/1ps
module sim_ccal_divider;
  localparam int PD = 8, SD = 4, SPM = 3, TD = 4;
  localparam int NOM = PD * SD;          // 32
  localparam int FRAME_S = 64 * SPM;     // 192 seconds

  localparam int NV = 8;
  localparam logic [5:0] VCAL [NV] = '{6'h00, 6'h21, 6'h26, 6'h01, 6'h3F, 6'h1F, 6'h20, 6'h10};
  localparam int         VTOT [NV] = '{6144, 6128, 6048, 6152, 5648, 6392, 6144, 6272};

  logic clk = 1'b0, rst_n = 1'b0, stop = 1'b0, div_clr = 1'b0;
  logic [5:0] trim_cfg = 6'h00;
  logic sec_pulse, min_pulse, test_wave;

  int checks = 0, errors = 0;
  int cyc = 0, last = 0, n_iv = 0, min_bad = 0;
  int iv [0:255];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ccal_divider #(.PRE_DIV(PD), .SEC_DIV(SD), .SEC_PER_MIN(SPM), .TST_DIV(TD)) u0 (
    .clk(clk), .rst_n(rst_n), .stop(stop), .div_clr(div_clr), .trim_cfg(trim_cfg),
    .sec_pulse(sec_pulse), .min_pulse(min_pulse), .test_wave(test_wave)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && sec_pulse) begin
      if (n_iv < 256) iv[n_iv] = cyc - last;
      last = cyc;
      n_iv = n_iv + 1;
      if (min_pulse != (n_iv % SPM == 0)) min_bad = min_bad + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic restart();
    @(negedge clk) div_clr = 1'b1;
    @(negedge clk) begin div_clr = 1'b0; last = cyc; n_iv = 0; min_bad = 0; end
  endtask

  task automatic wait_secs(input int k);
    while (n_iv < k) @(negedge clk);
  endtask

  task automatic count_rises(output int rises);
    logic prev;
    rises = 0;
    @(negedge clk) prev = test_wave;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (test_wave && !prev) rises++;
      prev = test_wave;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int tot, bad, rises;
    repeat (3) @(negedge clk);
    // R11: outputs low in reset
    chk(!sec_pulse && !min_pulse && !test_wave, "R11 reset outputs",
        {29'd0, sec_pulse, min_pulse, test_wave}, 0);
    rst_n = 1'b1;

    // Vector table: frame length per trim setting (R2, R3, R4, R5, R6)
    for (int v = 0; v < NV; v++) begin
      trim_cfg = VCAL[v];
      restart();
      wait_secs(FRAME_S);
      tot = 0;
      for (int i = 0; i < FRAME_S; i++) tot += iv[i];
      chk(tot == VTOT[v], $sformatf("R2 R6 frame total trim %0h", VCAL[v]), tot, VTOT[v]);
      chk(min_bad == 0, "R7 minute strobe alignment", min_bad, 0);
    end

    // R3: positions of corrected seconds, faster trim 6 steps
    trim_cfg = 6'h26;
    restart();
    wait_secs(60);
    bad = 0;
    for (int i = 0; i < 60; i++)
      if (iv[i] != (((i % SPM) == 0 && (i / SPM) < 12) ? NOM - PD : NOM)) bad++;
    chk(bad == 0, "R3 corrected second positions", bad, 0);

    // R4: faster trim shortens first second
    trim_cfg = 6'h21;
    restart();
    wait_secs(2);
    chk(iv[0] == NOM - PD, "R4 shortened second", iv[0], NOM - PD);
    chk(iv[1] == NOM, "R1 nominal second", iv[1], NOM);

    // R5: slower trim stretches first second
    trim_cfg = 6'h01;
    restart();
    wait_secs(2);
    chk(iv[0] == NOM + PD / 2, "R5 stretched second", iv[0], NOM + PD / 2);

    // R7: frame wraps and minute 0 is corrected again
    trim_cfg = 6'h21;
    restart();
    wait_secs(FRAME_S + 1);
    chk(iv[FRAME_S - SPM] == NOM, "R7 minute 63 uncorrected", iv[FRAME_S - SPM], NOM);
    chk(iv[FRAME_S] == NOM - PD, "R7 wrapped minute 0 corrected", iv[FRAME_S], NOM - PD);

    // R8: test wave period unaffected by extreme trims
    trim_cfg = 6'h3F;
    count_rises(rises);
    chk(rises == 400 / TD, "R8 test wave faster trim", rises, 400 / TD);
    trim_cfg = 6'h1F;
    count_rises(rises);
    chk(rises == 400 / TD, "R8 test wave slower trim", rises, 400 / TD);

    // R9: stop freezes counting and test output
    trim_cfg = 6'h00;
    restart();
    wait_secs(1);
    repeat (5) @(negedge clk);
    stop = 1'b1;
    begin
      logic held;
      held = test_wave;
      bad = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (test_wave != held || sec_pulse) bad++;
      end
    end
    stop = 1'b0;
    chk(bad == 0, "R9 frozen during stop", bad, 0);
    wait_secs(2);
    chk(iv[1] == NOM + 20, "R9 stretched by stop", iv[1], NOM + 20);

    // R10: clear mid-frame restarts second and frame
    trim_cfg = 6'h21;
    restart();
    wait_secs(20);
    repeat (10) @(negedge clk);
    restart();
    wait_secs(1);
    chk(iv[0] == NOM - PD, "R10 restart reaches frame start", iv[0], NOM - PD);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule